// File: doc/BRIEF.md
# Two-Phase Integrate-and-Fire Neuron

This block models a single digital neuron whose state is a signed 10-bit membrane voltage. Work inside one time step falls into two phases. While the step is open the neuron takes synaptic events over a valid/ready handshake. Each event names an axon type, and that type picks one of three signed synaptic strengths, which is added to the voltage. At the end of the step a synchronization request arrives. The neuron then sorts its voltage into one of three regions. If the voltage is above the threshold it fires a one-cycle spike and clears the voltage. If it is negative it clears the voltage without firing. In the middle region it adds a signed leak.

Before operation, a narrow write port loads the threshold, the leak and the three strengths. One saturating adder serves every update. During integration it adds voltage and strength. During the end-of-step phase it adds either voltage and leak, or zero and zero. Because each event is acknowledged only after its update is done, and the step-end request is refused while an event is pending, the result of a time step does not depend on how events and the step boundary arrive relative to each other.

Top module: `tpif_neuron`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` as an 8-bit two's complement value. Select code 0 is the threshold, code 1 the leak, and codes 2, 3 and 4 the strengths for types 0, 1 and 2. Reset clears all five values to zero.
- R2: An event of type 0, 1 or 2 adds that type's strength, sign-extended to 10 bits, to the voltage. The voltage changes only through events and synchronization.
- R3: An event of type 3 is acknowledged but leaves the voltage unchanged.
- R4: On synchronization, a voltage strictly greater than the sign-extended threshold produces a spike and sets the voltage to 0. A voltage equal to the threshold does not fire.
- R5: `spike` is high for exactly the one cycle after the clock edge that accepts synchronization, and `volt` reads 0 in that cycle.
- R6: On synchronization, a negative voltage that is not above the threshold becomes 0 and no spike is produced.
- R7: On synchronization, a voltage from 0 up to the threshold has the leak added and no spike is produced.
- R8: Every addition saturates at +511 and at -512 instead of wrapping.
- R9: `ev_ready` rises at the second clock edge after `ev_valid` is seen in the idle state, stays high for one cycle, and `volt` already holds the updated value in that cycle.
- R10: `sync_ready` is high only when the neuron is idle and `ev_valid` is low, so a pending event is always served before a synchronization request that arrives in the same cycle.
- R11: After reset, `volt` is 0, `spike` is 0, `ev_ready` is 0 and `sync_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_sel | input | 3 | Parameter select code |
| cfg_data | input | 8 | Parameter value, two's complement |
| ev_valid | input | 1 | Synaptic event request |
| ev_type | input | 2 | Axon type of the event |
| ev_ready | output | 1 | Event acknowledge after the update |
| sync_valid | input | 1 | Time-step synchronization request |
| sync_ready | output | 1 | Synchronization can be accepted |
| spike | output | 1 | One-cycle spike pulse |
| volt | output | 10 | Membrane voltage, two's complement |

## Verification
An event request and a synchronization request can be raised in the same cycle, and both need the shared adder. The bench raises both at one falling edge with a voltage that will cross the threshold once the event is added. It then checks three things: `sync_ready` stays low while the event is pending, the spike does not appear before the event's acknowledge, and after the synchronization the voltage is 0 with one spike. Such a result can only occur if the event was integrated first.

// File: rtl/tpif_pkg.sv
package tpif_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADD  = 2'd1,
      ST_ACK  = 2'd2
   } nrn_state_t;

   typedef enum logic [1:0] {
      CL_ABOVE = 2'd0,
      CL_MID   = 2'd1,
      CL_BELOW = 2'd2
   } vregion_t;

   localparam int unsigned SEL_THRESH = 0;
   localparam int unsigned SEL_LEAK   = 1;
   localparam int unsigned SEL_STR0   = 2;

endpackage

// File: rtl/tpif_cfg_bank.sv
module tpif_cfg_bank #(
   parameter int unsigned PW     = 8,
   parameter int unsigned NTYPES = 3,
   parameter int unsigned AW     = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [AW-1:0]                 sel_i,
   input  logic [PW-1:0]                 data_i,
   output logic [PW-1:0]                 thresh_o,
   output logic [PW-1:0]                 leak_o,
   output logic [NTYPES-1:0][PW-1:0]     str_o
);
   import tpif_pkg::*;

   if (AW < $clog2(SEL_STR0 + NTYPES)) begin : g_bad_aw
      $error("tpif_cfg_bank: select width too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thresh_o <= '0;
         leak_o   <= '0;
      end else if (we_i) begin
         if (sel_i == AW'(SEL_THRESH)) thresh_o <= data_i;
         if (sel_i == AW'(SEL_LEAK))   leak_o   <= data_i;
      end
   end

   for (genvar g = 0; g < NTYPES; g++) begin : g_str
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  str_o[g] <= '0;
         else if (we_i && sel_i == AW'(SEL_STR0 + g)) str_o[g] <= data_i;
      end
   end

endmodule

// File: rtl/tpif_sat_adder.sv
module tpif_sat_adder #(
   parameter int unsigned VW  = 10,
   parameter int unsigned PW  = 8,
   parameter bit          SAT = 1'b1
) (
   input  logic [VW-1:0] a_i,
   input  logic [PW-1:0] b_i,
   output logic [VW-1:0] sum_o
);
   localparam int unsigned EXT = VW + 1 - PW;

   if (VW <= PW) begin : g_bad_w
      $error("tpif_sat_adder: voltage must be wider than operand");
   end

   logic [VW:0] wide;
   assign wide = {a_i[VW-1], a_i} + {{EXT{b_i[PW-1]}}, b_i};

   if (SAT) begin : g_sat
      logic ovf;
      assign ovf   = wide[VW] ^ wide[VW-1];
      assign sum_o = ovf ? (wide[VW] ? {1'b1, {(VW-1){1'b0}}}
                                     : {1'b0, {(VW-1){1'b1}}})
                         : wide[VW-1:0];
      always_comb begin
         if (!a_i[VW-1] && !b_i[PW-1])
            AST_NO_WRAP_POS: assert (!sum_o[VW-1]); // R8
         if (a_i[VW-1] && b_i[PW-1])
            AST_NO_WRAP_NEG: assert (sum_o[VW-1]); // R8
      end
   end else begin : g_wrap
      assign sum_o = wide[VW-1:0];
   end

endmodule

// File: rtl/tpif_classify.sv
module tpif_classify #(
   parameter int unsigned VW = 10,
   parameter int unsigned PW = 8
) (
   input  logic [VW-1:0]        volt_i,
   input  logic [PW-1:0]        thresh_i,
   output tpif_pkg::vregion_t   region_o
);
   import tpif_pkg::*;

   logic [VW-1:0] thr_ext;
   assign thr_ext = {{(VW-PW){thresh_i[PW-1]}}, thresh_i};

   always_comb begin
      if ($signed(volt_i) > $signed(thr_ext)) region_o = CL_ABOVE;
      else if (volt_i[VW-1])                  region_o = CL_BELOW;
      else                                    region_o = CL_MID;
   end

endmodule

// File: rtl/tpif_neuron.sv
module tpif_neuron #(
   parameter int unsigned VW     = 10,
   parameter int unsigned PW     = 8,
   parameter int unsigned NTYPES = 3,
   parameter bit          SAT    = 1'b1,
   localparam int unsigned TW    = $clog2(NTYPES + 1),
   localparam int unsigned AW    = $clog2(NTYPES + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_sel,
   input  logic [PW-1:0] cfg_data,
   input  logic          ev_valid,
   input  logic [TW-1:0] ev_type,
   output logic          ev_ready,
   input  logic          sync_valid,
   output logic          sync_ready,
   output logic          spike,
   output logic [VW-1:0] volt
);
   import tpif_pkg::*;

   if (NTYPES < 1) begin : g_bad_types
      $error("tpif_neuron: need at least one synapse type");
   end

   nrn_state_t             state;
   logic [TW-1:0]          type_q;
   logic [PW-1:0]          thresh, leak, sel_str;
   logic [NTYPES-1:0][PW-1:0] str;
   vregion_t               region;
   logic [VW-1:0]          add_a, add_sum;
   logic [PW-1:0]          add_b;
   logic                   sync_fire;

   tpif_cfg_bank #(.PW(PW), .NTYPES(NTYPES), .AW(AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
      .data_i(cfg_data), .thresh_o(thresh), .leak_o(leak), .str_o(str)
   );

   tpif_classify #(.VW(VW), .PW(PW)) u_cls (
      .volt_i(volt), .thresh_i(thresh), .region_o(region)
   );

   tpif_sat_adder #(.VW(VW), .PW(PW), .SAT(SAT)) u_add (
      .a_i(add_a), .b_i(add_b), .sum_o(add_sum)
   );

   assign ev_ready   = (state == ST_ACK);
   assign sync_ready = (state == ST_IDLE) && !ev_valid;
   assign sync_fire  = sync_valid && sync_ready;

   always_comb begin
      sel_str = '0;
      for (int k = 0; k < NTYPES; k++)
         if (type_q == TW'(k)) sel_str = str[k];
   end

   // shared adder operand selection
   always_comb begin
      add_a = volt;
      add_b = '0;
      if (state == ST_ADD) begin
         add_b = sel_str;
      end else if (sync_fire) begin
         if (region == CL_MID) add_b = leak;
         else                  add_a = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         type_q <= '0;
         volt   <= '0;
         spike  <= 1'b0;
      end else begin
         spike <= sync_fire && (region == CL_ABOVE);
         case (state)
            ST_IDLE: begin
               if (ev_valid) begin
                  type_q <= ev_type;
                  state  <= ST_ADD;
               end else if (sync_fire) begin
                  volt <= add_sum;
               end
            end
            ST_ADD: begin
               volt  <= add_sum;
               state <= ST_ACK;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_ready && sync_ready)); // R10

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ready |=> !ev_ready); // R9

   AST_SPIKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      spike |-> (volt == '0)); // R5

   AST_BELOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_fire && region == CL_BELOW) |=> (volt == '0 && !spike)); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !sync_fire) |=> $stable(volt)); // R2

endmodule

// File: tb/tpif_neuron_tb.sv
`timescale 1ns/1ps
module tpif_neuron_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_sel = '0;
   logic [7:0] cfg_data = '0;
   logic       ev_valid = 1'b0;
   logic [1:0] ev_type = '0;
   logic       ev_ready;
   logic       sync_valid = 1'b0;
   logic       sync_ready;
   logic       spike;
   logic [9:0] volt;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   tpif_neuron u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .ev_valid(ev_valid), .ev_type(ev_type),
      .ev_ready(ev_ready), .sync_valid(sync_valid), .sync_ready(sync_ready),
      .spike(spike), .volt(volt)
   );

   // {op[1:0], arg[2:0], data[7:0], exp_volt[9:0], exp_spike}
   // op 0: config write, 1: event of type arg, 2: synchronization
   localparam int NV = 31;
   localparam logic [23:0] VEC [NV] = '{
      {2'd0, 3'd0, 8'd20,  10'd0,   1'b0},   // R1 threshold 20
      {2'd0, 3'd1, 8'hFD,  10'd0,   1'b0},   // R1 leak -3
      {2'd0, 3'd2, 8'd5,   10'd0,   1'b0},   // R1 strength type0 = 5
      {2'd0, 3'd3, 8'hF9,  10'd0,   1'b0},   // R1 strength type1 = -7
      {2'd0, 3'd4, 8'd127, 10'd0,   1'b0},   // R1 strength type2 = 127
      {2'd1, 3'd0, 8'd0,   10'd5,   1'b0},   // R2
      {2'd1, 3'd0, 8'd0,   10'd10,  1'b0},   // R2
      {2'd1, 3'd1, 8'd0,   10'd3,   1'b0},   // R2
      {2'd2, 3'd0, 8'd0,   10'd0,   1'b0},   // R7 3-3
      {2'd1, 3'd0, 8'd0,   10'd5,   1'b0},
      {2'd2, 3'd0, 8'd0,   10'd2,   1'b0},   // R7 5-3
      {2'd1, 3'd1, 8'd0,   10'h3FB, 1'b0},   // R2 -5
      {2'd2, 3'd0, 8'd0,   10'd0,   1'b0},   // R6
      {2'd1, 3'd2, 8'd0,   10'd127, 1'b0},
      {2'd2, 3'd0, 8'd0,   10'd0,   1'b1},   // R4
      {2'd1, 3'd0, 8'd0,   10'd5,   1'b0},
      {2'd1, 3'd0, 8'd0,   10'd10,  1'b0},
      {2'd1, 3'd0, 8'd0,   10'd15,  1'b0},
      {2'd1, 3'd0, 8'd0,   10'd20,  1'b0},
      {2'd2, 3'd0, 8'd0,   10'd17,  1'b0},   // R4 equal threshold: leak only
      {2'd1, 3'd0, 8'd0,   10'd22,  1'b0},
      {2'd2, 3'd0, 8'd0,   10'd0,   1'b1},   // R4
      {2'd1, 3'd2, 8'd0,   10'd127, 1'b0},
      {2'd1, 3'd2, 8'd0,   10'd254, 1'b0},
      {2'd1, 3'd2, 8'd0,   10'd381, 1'b0},
      {2'd1, 3'd2, 8'd0,   10'd508, 1'b0},
      {2'd1, 3'd2, 8'd0,   10'd511, 1'b0},   // R8 positive clamp
      {2'd2, 3'd0, 8'd0,   10'd0,   1'b1},
      {2'd1, 3'd0, 8'd0,   10'd5,   1'b0},
      {2'd1, 3'd3, 8'd0,   10'd5,   1'b0},   // R3 type 3 ignored
      {2'd2, 3'd0, 8'd0,   10'd2,   1'b0}    // R7
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_cfg(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      @(negedge clk);
   endtask

   // returns number of falling edges until ev_ready seen
   task automatic do_event(input logic [1:0] t, output int lat);
      @(negedge clk);
      ev_valid = 1'b1; ev_type = t;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!ev_ready && lat < 20);
      @(posedge clk); #1;
      ev_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_sync();
      int w;
      @(negedge clk);
      sync_valid = 1'b1;
      w = 0;
      while (!sync_ready && w < 20) begin
         @(negedge clk);
         w++;
      end
      @(posedge clk); #1;
      sync_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int lat;
      logic [23:0] v;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 volt", int'(volt), 0);
      chk("R11 spike", int'(spike), 0);
      chk("R11 ev_ready", int'(ev_ready), 0);
      chk("R11 sync_ready", int'(sync_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         case (v[23:22])
            2'd0: do_cfg(v[21:19], v[18:11]);
            2'd1: do_event(v[20:19], lat);
            default: do_sync();
         endcase
         chk($sformatf("R2/R4/R6/R7 vec%0d volt", i), int'(volt), int'(v[10:1]));
         chk($sformatf("R5 vec%0d spike", i), int'(spike), int'(v[0]));
      end

      // R5: spike lasts one cycle only
      do_event(2'd2, lat);
      do_sync();
      chk("R5 spike set", int'(spike), 1);
      @(negedge clk);
      chk("R5 spike one cycle", int'(spike), 0);

      // R9 acknowledge latency and value
      do_event(2'd0, lat);
      chk("R9 ack latency", lat, 2);
      chk("R9 volt after ack", int'(volt), 5);

      // R8 negative clamp: 5 - 7*80 < -512
      for (int k = 0; k < 80; k++) do_event(2'd1, lat);
      chk("R8 negative clamp", int'(volt), 10'h200);
      do_sync();
      chk("R6 clamp cleared", int'(volt), 0);
      chk("R6 no spike", int'(spike), 0);

      // R10 event and sync raised together
      @(negedge clk);
      ev_valid = 1'b1; ev_type = 2'd2; sync_valid = 1'b1;
      #0.5;
      chk("R10 sync refused with event pending", int'(sync_ready), 0);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         chk("R10 no early spike", int'(spike), 0);
      end while (!ev_ready && lat < 20);
      chk("R10 sync_ready during ack", int'(sync_ready), 0);
      @(posedge clk); #1;
      ev_valid = 1'b0;
      @(negedge clk);
      chk("R10 sync taken after event", int'(sync_ready), 1);
      @(posedge clk); #1;
      sync_valid = 1'b0;
      @(negedge clk);
      chk("R10 spike from integrated event", int'(spike), 1);
      chk("R10 volt cleared", int'(volt), 0);

      // R1 leak rewrite takes effect
      do_cfg(3'd1, 8'd4);
      do_event(2'd0, lat);
      do_sync();
      chk("R1 new leak", int'(volt), 9);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule